// File: doc/BRIEF.md
# Global Trigger Decision Unit

This block makes the final accept decision for a multi-crate detector trigger. Up to sixteen slave links each deliver a tagged 16-bit sub-trigger word together with a valid strobe. Every accepted word raises a one-cycle presence flag for its link and replaces that link's held 12-bit hit count. Links sit at different cable and processing distances, so each presence flag runs through its own programmable delay line before the decision logic sees it.

The aligned flags are split into four fixed groups of four links. Each group is hit when any of its enabled flags is set. A runtime mode selects how the four group hits combine. When the selected pattern is met and the sum of the enabled links' held counts is strictly above a programmed threshold, the block emits a single-cycle global trigger pulse. It also counts those pulses and presents the held per-link counts for readout.

Top module: `gtrig_decider`

## Requirements
- R1: A word is accepted when its link's valid is high and bits [15:12] equal 4'b0100. The word's bits [11:0] then appear on that link's 12-bit slice of `hit_counts` (link i at bits [12*i+11:12*i]) after the next clock edge.
- R2: A word with any other tag, or with valid low, leaves that link's held count unchanged and raises no presence flag.
- R3: The delay field of link i, `cfg_delay[4*i+3:4*i]`, ranges from 0 to 15. A flag from a word sampled at edge E0 contributes to a `trig_pulse` that is high right after edge E0+1+delay.
- R4: Group A is links 0-3, group B is links 4-7, group C is links 8-11 and group D is links 12-15. A group is hit when at least one of its enabled aligned flags is set.
- R5: `cfg_mode` selects the pattern across the groups: 0 is A|B|C|D, 1 is A&B&C&D, 2 is (A&B)|(C&D), and 3 is (A|B)&(C|D).
- R6: The trigger also requires the sum of the held counts of all enabled links to be strictly greater than `cfg_threshold`. A sum equal to the threshold does not fire.
- R7: A link whose `cfg_enable` bit is 0 contributes neither its flag nor its count to the decision. Its count is still loaded and shown on `hit_counts`.
- R8: `trig_pulse` is high for exactly one cycle on each rising edge of the decision condition, even while the condition stays true.
- R9: `event_count` increments by one on the same edge that raises `trig_pulse` and holds otherwise.
- R10: During reset, `trig_pulse` is 0 and every held count, every delay line and `event_count` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_word | input | 256 | Sixteen 16-bit sub-trigger words, link i at bits [16*i+15:16*i] |
| link_valid | input | 16 | Word strobe, one bit per link |
| cfg_enable | input | 16 | Participation mask, one bit per link |
| cfg_delay | input | 64 | Per-link alignment delay in cycles, 4 bits per link |
| cfg_mode | input | 2 | Group combination select |
| cfg_threshold | input | 16 | Total hit count that must be exceeded |
| trig_pulse | output | 1 | One-cycle global trigger |
| hit_counts | output | 192 | Held 12-bit count for each link |
| event_count | output | 16 | Number of global triggers since reset |

## Verification
A count load is visible one edge after the word is sampled. The trigger pulse comes 1+d edges after the sample edge, where d is the delay of the latest aligned link. The event counter steps on that same edge. The bench drives inputs and samples outputs 1 ns after a rising edge. It then walks a window of cycles after each stimulus and checks at every one of them that the pulse is present only at the computed offset, so a pulse that arrives early, late or twice is reported. Delayed links are fed on successive cycles with delays chosen to make them coincide, and the same schedule is repeated with zero delays to show that misaligned flags do not fire.

// File: rtl/gtrig_pkg.sv
package gtrig_pkg;

    typedef enum logic [1:0] {
        MODE_ANY      = 2'd0,
        MODE_ALL      = 2'd1,
        MODE_PAIR_AND = 2'd2,
        MODE_PAIR_OR  = 2'd3
    } combine_mode_e;

    localparam int unsigned WORD_W     = 16;
    localparam int unsigned TAG_W      = 4;
    localparam logic [3:0]  TAG_ACCEPT = 4'b0100;
    localparam int unsigned N_GROUP    = 4;

endpackage

// File: rtl/gtrig_link_decode.sv
module gtrig_link_decode
    import gtrig_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic              valid_i,
    output logic              flag_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam int unsigned TAG_LSB = WORD_W - TAG_W;

    typedef struct packed {
        logic             flag;
        logic [CNT_W-1:0] cnt;
    } dec_state_t;

    dec_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = valid_i && (word_i[WORD_W-1:TAG_LSB] == TAG_ACCEPT);
        if (st_d.flag) begin
            st_d.cnt = word_i[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign cnt_o  = st_q.cnt;

endmodule

// File: rtl/gtrig_align_delay.sv
module gtrig_align_delay #(
    parameter int unsigned MAX_DLY = 15,
    localparam int unsigned DLY_W  = $clog2(MAX_DLY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             flag_i,
    output logic             flag_o
);
    typedef struct packed {
        logic [MAX_DLY-1:0] taps;
    } dly_state_t;

    dly_state_t st_d, st_q;

    always_comb begin
        st_d.taps = {st_q.taps[MAX_DLY-2:0], flag_i};
    end

    always_comb begin
        flag_o = flag_i;
        for (int i = 0; i < int'(MAX_DLY); i++) begin
            if (int'(dly_i) == i + 1) begin
                flag_o = st_q.taps[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gtrig_pattern.sv
module gtrig_pattern
    import gtrig_pkg::*;
#(
    parameter int unsigned N_LINK   = 16,
    parameter int unsigned CNT_W    = 12,
    localparam int unsigned GRP_SZ  = N_LINK / N_GROUP,
    localparam int unsigned SUM_W   = CNT_W + $clog2(N_LINK)
) (
    input  logic [N_LINK-1:0]       flags_i,
    input  logic [N_LINK-1:0]       enable_i,
    input  logic [N_LINK*CNT_W-1:0] counts_i,
    input  logic [1:0]              mode_i,
    input  logic [SUM_W-1:0]        threshold_i,
    output logic                    cond_o
);
    logic [N_GROUP-1:0] grp_hit;
    logic [N_LINK-1:0]  live;
    logic [SUM_W-1:0]   total;
    logic               pattern_ok;
    combine_mode_e      mode;

    assign live = flags_i & enable_i;
    assign mode = combine_mode_e'(mode_i);

    for (genvar g = 0; g < int'(N_GROUP); g++) begin : g_grp
        assign grp_hit[g] = |live[g*GRP_SZ +: GRP_SZ];
    end

    always_comb begin
        total = '0;
        for (int i = 0; i < int'(N_LINK); i++) begin
            if (enable_i[i]) begin
                total = total + SUM_W'(counts_i[i*CNT_W +: CNT_W]);
            end
        end
    end

    always_comb begin
        unique case (mode)
            MODE_ANY:      pattern_ok = |grp_hit;
            MODE_ALL:      pattern_ok = &grp_hit;
            MODE_PAIR_AND: pattern_ok = (grp_hit[0] & grp_hit[1]) | (grp_hit[2] & grp_hit[3]);
            MODE_PAIR_OR:  pattern_ok = (grp_hit[0] | grp_hit[1]) & (grp_hit[2] | grp_hit[3]);
            default:       pattern_ok = 1'b0;
        endcase
    end

    assign cond_o = pattern_ok && (total > threshold_i);

endmodule

// File: rtl/gtrig_decider.sv
module gtrig_decider
    import gtrig_pkg::*;
#(
    parameter int unsigned N_LINK  = 16,
    parameter int unsigned CNT_W   = 12,
    parameter int unsigned MAX_DLY = 15,
    parameter int unsigned EVT_W   = 16,
    localparam int unsigned DLY_W  = $clog2(MAX_DLY + 1),
    localparam int unsigned SUM_W  = CNT_W + $clog2(N_LINK)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_LINK*WORD_W-1:0] link_word,
    input  logic [N_LINK-1:0]        link_valid,
    input  logic [N_LINK-1:0]        cfg_enable,
    input  logic [N_LINK*DLY_W-1:0]  cfg_delay,
    input  logic [1:0]               cfg_mode,
    input  logic [SUM_W-1:0]         cfg_threshold,
    output logic                     trig_pulse,
    output logic [N_LINK*CNT_W-1:0]  hit_counts,
    output logic [EVT_W-1:0]         event_count
);
    logic [N_LINK-1:0] raw_flag;
    logic [N_LINK-1:0] aligned_flag;
    logic              cond;

    for (genvar i = 0; i < int'(N_LINK); i++) begin : g_link
        gtrig_link_decode #(
            .CNT_W (CNT_W)
        ) u_dec (
            .clk     (clk),
            .rst_n   (rst_n),
            .word_i  (link_word[i*WORD_W +: WORD_W]),
            .valid_i (link_valid[i]),
            .flag_o  (raw_flag[i]),
            .cnt_o   (hit_counts[i*CNT_W +: CNT_W])
        );

        gtrig_align_delay #(
            .MAX_DLY (MAX_DLY)
        ) u_dly (
            .clk    (clk),
            .rst_n  (rst_n),
            .dly_i  (cfg_delay[i*DLY_W +: DLY_W]),
            .flag_i (raw_flag[i]),
            .flag_o (aligned_flag[i])
        );
    end

    gtrig_pattern #(
        .N_LINK (N_LINK),
        .CNT_W  (CNT_W)
    ) u_pat (
        .flags_i     (aligned_flag),
        .enable_i    (cfg_enable),
        .counts_i    (hit_counts),
        .mode_i      (cfg_mode),
        .threshold_i (cfg_threshold),
        .cond_o      (cond)
    );

    typedef struct packed {
        logic             cond;
        logic             trig;
        logic [EVT_W-1:0] evt;
    } dec_top_t;

    dec_top_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.cond = cond;
        st_d.trig = cond && !st_q.cond;
        if (st_d.trig) begin
            st_d.evt = st_q.evt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_pulse  = st_q.trig;
    assign event_count = st_q.evt;

endmodule

// File: rtl/gtrig_checker.sv
module gtrig_checker
    import gtrig_pkg::*;
#(
    parameter int unsigned N_LINK  = 16,
    parameter int unsigned CNT_W   = 12,
    parameter int unsigned MAX_DLY = 15,
    parameter int unsigned EVT_W   = 16,
    localparam int unsigned DLY_W  = $clog2(MAX_DLY + 1),
    localparam int unsigned SUM_W  = CNT_W + $clog2(N_LINK)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_LINK*WORD_W-1:0] link_word,
    input logic [N_LINK-1:0]        link_valid,
    input logic [N_LINK-1:0]        cfg_enable,
    input logic [N_LINK*DLY_W-1:0]  cfg_delay,
    input logic [1:0]               cfg_mode,
    input logic [SUM_W-1:0]         cfg_threshold,
    input logic                     trig_pulse,
    input logic [N_LINK*CNT_W-1:0]  hit_counts,
    input logic [EVT_W-1:0]         event_count
);
    logic [SUM_W-1:0] seen_total;

    always_comb begin
        seen_total = '0;
        for (int i = 0; i < int'(N_LINK); i++) begin
            if (cfg_enable[i]) begin
                seen_total = seen_total + SUM_W'(hit_counts[i*CNT_W +: CNT_W]);
            end
        end
    end

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);

    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_pulse) |-> event_count == $past(event_count) + 1'b1);

    a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_pulse |-> $stable(event_count));

    a_r6_over_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> $past(seen_total) > $past(cfg_threshold));

    a_r10_idle_in_reset: assert property (@(posedge clk)
        !rst_n |=> !trig_pulse);

    for (genvar i = 0; i < int'(N_LINK); i++) begin : g_lane
        a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
            (link_valid[i] && link_word[i*WORD_W + WORD_W - TAG_W +: TAG_W] == TAG_ACCEPT)
            |=> hit_counts[i*CNT_W +: CNT_W] == $past(link_word[i*WORD_W +: CNT_W]));

        a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(link_valid[i] && link_word[i*WORD_W + WORD_W - TAG_W +: TAG_W] == TAG_ACCEPT)
            |=> $stable(hit_counts[i*CNT_W +: CNT_W]));
    end

    logic unused_ok;
    assign unused_ok = ^{cfg_delay, cfg_mode};

endmodule

bind gtrig_decider gtrig_checker #(
    .N_LINK  (N_LINK),
    .CNT_W   (CNT_W),
    .MAX_DLY (MAX_DLY),
    .EVT_W   (EVT_W)
) u_gtrig_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .link_word     (link_word),
    .link_valid    (link_valid),
    .cfg_enable    (cfg_enable),
    .cfg_delay     (cfg_delay),
    .cfg_mode      (cfg_mode),
    .cfg_threshold (cfg_threshold),
    .trig_pulse    (trig_pulse),
    .hit_counts    (hit_counts),
    .event_count   (event_count)
);

// File: tb/gtrig_decider_bench.sv
module gtrig_decider_bench;
    localparam int NL = 16;
    localparam int CW = 12;
    localparam int DW = 4;
    localparam int SW = 16;
    localparam int EW = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NL*16-1:0] link_word;
    logic [NL-1:0]    link_valid;
    logic [NL-1:0]    cfg_enable;
    logic [NL*DW-1:0] cfg_delay;
    logic [1:0]       cfg_mode;
    logic [SW-1:0]    cfg_threshold;
    logic             trig_pulse;
    logic [NL*CW-1:0] hit_counts;
    logic [EW-1:0]    event_count;

    int checks = 0;
    int errors = 0;
    int exp_evt = 0;

    always #2 clk = ~clk;

    gtrig_decider u_gtrig_decider (
        .clk           (clk),
        .rst_n         (rst_n),
        .link_word     (link_word),
        .link_valid    (link_valid),
        .cfg_enable    (cfg_enable),
        .cfg_delay     (cfg_delay),
        .cfg_mode      (cfg_mode),
        .cfg_threshold (cfg_threshold),
        .trig_pulse    (trig_pulse),
        .hit_counts    (hit_counts),
        .event_count   (event_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n         = 1'b0;
        link_word     = '0;
        link_valid    = '0;
        cfg_enable    = '1;
        cfg_delay     = '0;
        cfg_mode      = 2'd0;
        cfg_threshold = '0;
        repeat (3) tick();
        rst_n   = 1'b1;
        exp_evt = 0;
        tick();
    endtask

    task automatic put(input int l, input logic [3:0] tag, input int c);
        link_word[l*16 +: 16] = {tag, 12'(c)};
        link_valid[l]         = 1'b1;
    endtask

    task automatic set_dly(input int l, input int d);
        cfg_delay[l*DW +: DW] = DW'(d);
    endtask

    task automatic check_cnt(input int l, input int exp, input string req);
        chk(hit_counts[l*CW +: CW] == CW'(exp), req, $sformatf("count link %0d", l),
            hit_counts[l*CW +: CW], exp);
    endtask

    // Samples 'win' cycles; pulse expected only at offset exp_at (-1: never).
    task automatic watch(input int exp_at, input int win, input string req);
        for (int k = 1; k <= win; k++) begin
            tick();
            chk(trig_pulse == (k == exp_at), req, $sformatf("trig at offset %0d", k),
                trig_pulse, (k == exp_at));
        end
        if (exp_at > 0) exp_evt++;
        chk(event_count == EW'(exp_evt), "R9", "event count", event_count, exp_evt);
    endtask

    task automatic t_reset();
        do_reset();
        chk(trig_pulse == 1'b0, "R10", "trig after reset", trig_pulse, 0);
        chk(hit_counts == '0, "R10", "counts after reset", hit_counts, 0);
        chk(event_count == '0, "R10", "event count after reset", event_count, 0);
    endtask

    task automatic t_load_threshold();
        do_reset();
        cfg_threshold = 16'd10;
        put(3, 4'b0100, 10);
        tick();
        link_valid = '0;
        check_cnt(3, 10, "R1");
        watch(-1, 3, "R6");            // sum equals threshold: no fire
        cfg_threshold = 16'd9;
        put(3, 4'b0100, 10);
        tick();
        link_valid = '0;
        watch(1, 3, "R6");
    endtask

    task automatic t_bad_tag();
        do_reset();
        put(3, 4'b0100, 9);
        tick();
        link_valid = '0;
        watch(1, 2, "R1");
        put(3, 4'b0101, 1);
        tick();
        link_valid = '0;
        check_cnt(3, 9, "R2");
        watch(-1, 3, "R2");
        put(3, 4'b0100, 5);
        link_valid[3] = 1'b0;          // good tag but no strobe
        tick();
        check_cnt(3, 9, "R2");
        watch(-1, 2, "R2");
    endtask

    task automatic t_align_all();
        do_reset();
        cfg_mode = 2'd1;
        set_dly(0, 3); set_dly(4, 2); set_dly(8, 1); set_dly(12, 0);
        put(0, 4'b0100, 1);  tick(); link_valid = '0;
        put(4, 4'b0100, 1);  tick(); link_valid = '0;
        put(8, 4'b0100, 1);  tick(); link_valid = '0;
        put(12, 4'b0100, 1); tick(); link_valid = '0;
        watch(1, 4, "R3");
        cfg_delay = '0;                 // same schedule, no alignment
        put(0, 4'b0100, 1);  tick(); link_valid = '0;
        put(4, 4'b0100, 1);  tick(); link_valid = '0;
        put(8, 4'b0100, 1);  tick(); link_valid = '0;
        put(12, 4'b0100, 1); tick(); link_valid = '0;
        watch(-1, 4, "R5");
    endtask

    task automatic t_pair_and();
        do_reset();
        cfg_mode = 2'd2;
        put(1, 4'b0100, 2); put(6, 4'b0100, 2);
        tick(); link_valid = '0;
        watch(1, 3, "R5");
        put(1, 4'b0100, 2); put(9, 4'b0100, 2);
        tick(); link_valid = '0;
        watch(-1, 3, "R4");
    endtask

    task automatic t_pair_or();
        do_reset();
        cfg_mode = 2'd3;
        put(2, 4'b0100, 3); put(15, 4'b0100, 3);
        tick(); link_valid = '0;
        watch(1, 3, "R5");
        put(2, 4'b0100, 3); put(7, 4'b0100, 3);
        tick(); link_valid = '0;
        watch(-1, 3, "R4");
    endtask

    task automatic t_mask();
        do_reset();
        cfg_enable[5] = 1'b0;
        cfg_threshold = 16'd50;
        put(5, 4'b0100, 100); put(6, 4'b0100, 2);
        tick(); link_valid = '0;
        check_cnt(5, 100, "R7");
        watch(-1, 3, "R7");            // masked count excluded: sum 2
        cfg_threshold = 16'd1;
        put(5, 4'b0100, 100);
        tick(); link_valid = '0;
        watch(-1, 3, "R7");            // masked flag ignored
    endtask

    task automatic t_max_delay();
        do_reset();
        set_dly(10, 15);
        put(10, 4'b0100, 4);
        tick(); link_valid = '0;
        watch(16, 18, "R3");
    endtask

    task automatic t_single_pulse();
        do_reset();
        put(2, 4'b0100, 7);
        tick();                          // E0, valid stays high
        tick();
        chk(trig_pulse == 1'b1, "R8", "first pulse", trig_pulse, 1);
        exp_evt++;
        tick();
        link_valid = '0;
        chk(trig_pulse == 1'b0, "R8", "held condition", trig_pulse, 0);
        watch(-1, 3, "R8");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_load_threshold();
        t_bad_tag();
        t_align_all();
        t_pair_and();
        t_pair_or();
        t_mask();
        t_max_delay();
        t_single_pulse();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule